// File: doc/BRIEF.md
# Packet Address Filter and Router

This block sits between a receive character FIFO and the packet consumers of a serial link endpoint. It reads each packet's leading characters, decides whether the packet belongs to one of several DMA channels, to a remote memory access (RMAP) command target, or to nobody, and then passes the packet's data characters on to the chosen consumer. Packets that nobody takes are consumed silently up to their end marker.

Each channel has its own address and mask pair and a flag that picks either that pair or a shared default pair. A mask bit of 1 excludes the matching address bit from the comparison, so one channel can take a whole address range. The block holds at most three characters while it decides. It then replays them in arrival order and streams the rest of the packet. The input is a pull interface: characters are taken only while `rx_ready` is high. One decision pulse reports each packet's fate, including the packets it drops.

Top module: `pkt_route_filter`

## Requirements
- R1: The first data character of a packet is its address. Channel i matches when it is enabled and, for every bit where its effective mask is 0, the address bit equals the bit of its effective address. Bits whose mask is 1 are ignored.
- R2: A packet delivered to DMA goes to the lowest-numbered matching channel. A channel whose `ch_en` bit is 0 is never chosen.
- R3: When `ch_sep[i]` is 1, channel i uses its own slice of `ch_addr`/`ch_mask` (bits i*8+7..i*8). When it is 0, channel i uses `dflt_addr`/`dflt_mask`.
- R4: A packet is an RMAP command when `rmap_en` is 1, its second character is 0x01 and bit 6 of its third character is 1. Such a command goes to the RMAP target when the address matches the default pair. Any other packet, including one with bit 6 clear or one seen while `rmap_en` is 0, follows the plain channel rules.
- R5: An RMAP command that misses the default pair goes to the lowest matching DMA channel. If no channel matches, it goes to the RMAP target.
- R6: A packet with no destination produces no data and no end strobe. All of its characters, up to and including its end marker, are consumed. The next packet is then handled normally.
- R7: A packet needs at least 2 data characters to be delivered, or 1 when `promisc` is 1. With `rmap_en` at 1, a packet whose second character is 0x01 and that ends before a third character is dropped. An empty packet is dropped.
- R8: Every data character of a delivered packet, including the address and the second character, appears once and in order on `out_data`. The end marker is not forwarded as data. It appears as an `out_end` pulse after the last character, with `out_end_err` set to 1 for an error end (`rx_kind`=2) and to 0 for a normal end (`rx_kind`=1). `rx_kind`=0 is a data character.
- R9: Each packet produces exactly one `dec_valid` pulse. `dec_kind` is 0 for drop, 1 for DMA (with `dec_chan` set to the channel) and 2 for RMAP. For a delivered packet the pulse comes in the cycle just before its first `out_valid`.
- R10: After reset, `out_valid`, `out_end` and `dec_valid` are 0 and `rx_ready` is 1.
- R11: While a packet's characters stream out, `out_kind` and `out_chan` hold that packet's destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Input character present |
| rx_kind | input | 2 | 0 data, 1 normal end, 2 error end |
| rx_data | input | DW | Character value |
| rx_ready | output | 1 | Character taken this cycle when rx_valid is high |
| dflt_addr | input | DW | Shared default address |
| dflt_mask | input | DW | Shared default mask (1 = ignore bit) |
| ch_addr | input | N_CH*DW | Per-channel addresses, channel i in slice i |
| ch_mask | input | N_CH*DW | Per-channel masks, channel i in slice i |
| ch_sep | input | N_CH | Channel uses its own pair when 1 |
| ch_en | input | N_CH | Channel enable |
| promisc | input | 1 | Lowers the minimum length to one character |
| rmap_en | input | 1 | RMAP target present |
| dec_valid | output | 1 | One-cycle decision pulse per packet |
| dec_kind | output | 2 | 0 drop, 1 DMA, 2 RMAP |
| dec_chan | output | CW | Chosen DMA channel |
| out_valid | output | 1 | Forwarded character valid |
| out_data | output | DW | Forwarded character |
| out_end | output | 1 | Packet end strobe |
| out_end_err | output | 1 | Packet ended with an error marker |
| out_kind | output | 2 | Destination of the streaming packet |
| out_chan | output | CW | DMA channel of the streaming packet |

## Verification
A corrupted hold register or replay index shows up on `out_data` within three cycles of the decision pulse, as a missing, repeated or reordered leading character. A wrong match, priority or RMAP outcome appears on the very next `dec_kind`/`dec_chan` pulse. A state machine that does not discard to the end marker shows up on the next packet, whose decision and data no longer line up with the packet boundaries. The reference model predicts the decision, the character stream and the end flag of every packet, and compares them on every clock. This includes back-to-back packets and pseudo-random packets of length 0 to 5.

// File: rtl/pkt_route_pkg.sv
package pkt_route_pkg;
  typedef enum logic [1:0] {
    ROUTE_DROP = 2'd0,
    ROUTE_DMA  = 2'd1,
    ROUTE_RMAP = 2'd2
  } route_e;

  localparam logic [1:0] CK_DATA = 2'd0;
  localparam logic [1:0] CK_EOP  = 2'd1;
  localparam logic [1:0] CK_EEP  = 2'd2;

  localparam logic [7:0] RMAP_PROTO   = 8'h01;
  localparam int         RMAP_CMD_BIT = 6;
  localparam int         HOLD_CHARS   = 3;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_DECIDE,
    ST_REPLAY,
    ST_FORWARD,
    ST_DISCARD,
    ST_FINISH
  } rt_state_e;
endpackage

// File: rtl/pkt_route_match.sv
module pkt_route_match #(
  parameter int N_CH = 4,
  parameter int DW   = 8,
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [DW-1:0]      addr,
  input  logic [DW-1:0]      dflt_addr,
  input  logic [DW-1:0]      dflt_mask,
  input  logic [N_CH*DW-1:0] ch_addr,
  input  logic [N_CH*DW-1:0] ch_mask,
  input  logic [N_CH-1:0]    ch_sep,
  input  logic [N_CH-1:0]    ch_en,
  output logic               dflt_hit,
  output logic               dma_hit,
  output logic [CW-1:0]      dma_idx
);
  logic [N_CH-1:0] hit;

  assign dflt_hit = ((addr ^ dflt_addr) & ~dflt_mask) == '0;

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    logic [DW-1:0] eff_a;
    logic [DW-1:0] eff_m;
    assign eff_a  = ch_sep[g] ? ch_addr[g*DW +: DW] : dflt_addr;
    assign eff_m  = ch_sep[g] ? ch_mask[g*DW +: DW] : dflt_mask;
    assign hit[g] = ch_en[g] && (((addr ^ eff_a) & ~eff_m) == '0);
  end

  // lowest index wins: scan from the top so lower hits overwrite
  always_comb begin
    dma_hit = 1'b0;
    dma_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        dma_hit = 1'b1;
        dma_idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/pkt_route_decide.sv
module pkt_route_decide
  import pkt_route_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] proto_ch,
  input  logic [DW-1:0] cmd_ch,
  input  logic [1:0]    n_chars,
  input  logic          promisc,
  input  logic          rmap_en,
  input  logic          dflt_hit,
  input  logic          dma_hit,
  output route_e        route
);
  logic rmap_tag;
  logic min_ok;

  assign rmap_tag = rmap_en && (n_chars >= 2'd2) && (proto_ch == DW'(RMAP_PROTO));
  assign min_ok   = (n_chars >= (promisc ? 2'd1 : 2'd2));

  always_comb begin
    route = ROUTE_DROP;
    if (rmap_tag && n_chars < 2'd3) begin
      route = ROUTE_DROP;
    end else if (rmap_tag && cmd_ch[RMAP_CMD_BIT]) begin
      if (dflt_hit)     route = ROUTE_RMAP;
      else if (dma_hit) route = ROUTE_DMA;
      else              route = ROUTE_RMAP;
    end else if (min_ok && dma_hit) begin
      route = ROUTE_DMA;
    end
  end
endmodule

// File: rtl/pkt_route_filter.sv
module pkt_route_filter
  import pkt_route_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int DW   = 8,
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [1:0]         rx_kind,
  input  logic [DW-1:0]      rx_data,
  output logic               rx_ready,
  input  logic [DW-1:0]      dflt_addr,
  input  logic [DW-1:0]      dflt_mask,
  input  logic [N_CH*DW-1:0] ch_addr,
  input  logic [N_CH*DW-1:0] ch_mask,
  input  logic [N_CH-1:0]    ch_sep,
  input  logic [N_CH-1:0]    ch_en,
  input  logic               promisc,
  input  logic               rmap_en,
  output logic               dec_valid,
  output logic [1:0]         dec_kind,
  output logic [CW-1:0]      dec_chan,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  output logic               out_end,
  output logic               out_end_err,
  output logic [1:0]         out_kind,
  output logic [CW-1:0]      out_chan
);
  rt_state_e     state;
  logic [1:0]    cnt;
  logic [1:0]    rp_idx;
  logic          ended;
  logic          end_err;
  logic [DW-1:0] hold_q [HOLD_CHARS];

  logic          acc;
  logic          is_data;
  logic          dflt_hit;
  logic          dma_hit;
  logic [CW-1:0] dma_idx;
  route_e        route;

  assign rx_ready = (state == ST_COLLECT) || (state == ST_FORWARD) || (state == ST_DISCARD);
  assign acc      = rx_valid && rx_ready;
  assign is_data  = (rx_kind == CK_DATA);

  pkt_route_match #(.N_CH(N_CH), .DW(DW)) u_match (
    .addr      (hold_q[0]),
    .dflt_addr (dflt_addr),
    .dflt_mask (dflt_mask),
    .ch_addr   (ch_addr),
    .ch_mask   (ch_mask),
    .ch_sep    (ch_sep),
    .ch_en     (ch_en),
    .dflt_hit  (dflt_hit),
    .dma_hit   (dma_hit),
    .dma_idx   (dma_idx)
  );

  pkt_route_decide #(.DW(DW)) u_decide (
    .proto_ch (hold_q[1]),
    .cmd_ch   (hold_q[2]),
    .n_chars  (cnt),
    .promisc  (promisc),
    .rmap_en  (rmap_en),
    .dflt_hit (dflt_hit),
    .dma_hit  (dma_hit),
    .route    (route)
  );

  // hold registers: no reset, written only while collecting
  always_ff @(posedge clk) begin
    if (state == ST_COLLECT && acc && is_data) hold_q[cnt] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_COLLECT;
      cnt         <= '0;
      rp_idx      <= '0;
      ended       <= 1'b0;
      end_err     <= 1'b0;
      dec_valid   <= 1'b0;
      dec_kind    <= '0;
      dec_chan    <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_end     <= 1'b0;
      out_end_err <= 1'b0;
      out_kind    <= '0;
      out_chan    <= '0;
    end else begin
      dec_valid <= 1'b0;
      out_valid <= 1'b0;
      out_end   <= 1'b0;
      unique case (state)
        ST_COLLECT: begin
          if (acc) begin
            if (is_data) begin
              cnt <= cnt + 2'd1;
              if (cnt == 2'd2) begin
                ended <= 1'b0;
                state <= ST_DECIDE;
              end
            end else begin
              ended   <= 1'b1;
              end_err <= (rx_kind == CK_EEP);
              state   <= ST_DECIDE;
            end
          end
        end
        ST_DECIDE: begin
          dec_valid <= 1'b1;
          dec_kind  <= route;
          dec_chan  <= (route == ROUTE_DMA) ? dma_idx : '0;
          rp_idx    <= '0;
          if (route == ROUTE_DROP) begin
            cnt   <= '0;
            state <= ended ? ST_COLLECT : ST_DISCARD;
          end else begin
            out_kind <= route;
            out_chan <= (route == ROUTE_DMA) ? dma_idx : '0;
            state    <= ST_REPLAY;
          end
        end
        ST_REPLAY: begin
          out_valid <= 1'b1;
          out_data  <= hold_q[rp_idx];
          rp_idx    <= rp_idx + 2'd1;
          if (rp_idx == cnt - 2'd1) begin
            cnt   <= '0;
            state <= ended ? ST_FINISH : ST_FORWARD;
          end
        end
        ST_FINISH: begin
          out_end     <= 1'b1;
          out_end_err <= end_err;
          state       <= ST_COLLECT;
        end
        ST_FORWARD: begin
          if (acc) begin
            if (is_data) begin
              out_valid <= 1'b1;
              out_data  <= rx_data;
            end else begin
              out_end     <= 1'b1;
              out_end_err <= (rx_kind == CK_EEP);
              state       <= ST_COLLECT;
            end
          end
        end
        ST_DISCARD: begin
          if (acc && !is_data) state <= ST_COLLECT;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [1:0]      fwd_cnt;
  logic [N_CH-1:0] dec_sel;
  assign dec_sel = N_CH'(1) << dec_chan;

  always_ff @(posedge clk) begin
    if (rst || dec_valid) fwd_cnt <= '0;
    else if (out_valid && fwd_cnt != 2'd3) fwd_cnt <= fwd_cnt + 2'd1;
  end

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_end && !dec_valid && rx_ready));

  p_first_char_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind != 2'd0) |=> out_valid);

  p_legal_kind_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_kind != 2'd3));

  p_drop_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == 2'd0) |=> (!out_valid && !out_end));

  p_chan_enabled_r2: assert property (@(posedge clk) disable iff (rst || $past(rst))
    (dec_valid && dec_kind == 2'd1) |-> |($past(ch_en) & dec_sel));

  p_min_len_r7: assert property (@(posedge clk) disable iff (rst)
    out_end |-> ((fwd_cnt >= 2'd2) || (promisc && fwd_cnt >= 2'd1)));

  p_kind_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> ($stable(out_kind) && $stable(out_chan)));
endmodule

// File: tb/pkt_route_filter_tb_top.sv
module pkt_route_filter_tb_top;
  localparam int N_CH = 4;
  localparam int DW   = 8;
  localparam int CW   = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst;
  logic               rx_valid;
  logic [1:0]         rx_kind;
  logic [DW-1:0]      rx_data;
  logic               rx_ready;
  logic [DW-1:0]      dflt_addr, dflt_mask;
  logic [N_CH*DW-1:0] ch_addr, ch_mask;
  logic [N_CH-1:0]    ch_sep, ch_en;
  logic               promisc, rmap_en;
  logic               dec_valid;
  logic [1:0]         dec_kind;
  logic [CW-1:0]      dec_chan;
  logic               out_valid;
  logic [DW-1:0]      out_data;
  logic               out_end, out_end_err;
  logic [1:0]         out_kind;
  logic [CW-1:0]      out_chan;

  logic [7:0] a_cfg [N_CH];
  logic [7:0] m_cfg [N_CH];

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      ch_addr[i*DW +: DW] = a_cfg[i];
      ch_mask[i*DW +: DW] = m_cfg[i];
    end
  end

  pkt_route_filter #(.N_CH(N_CH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_data(rx_data), .rx_ready(rx_ready),
    .dflt_addr(dflt_addr), .dflt_mask(dflt_mask),
    .ch_addr(ch_addr), .ch_mask(ch_mask), .ch_sep(ch_sep), .ch_en(ch_en),
    .promisc(promisc), .rmap_en(rmap_en),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_chan(dec_chan),
    .out_valid(out_valid), .out_data(out_data),
    .out_end(out_end), .out_end_err(out_end_err),
    .out_kind(out_kind), .out_chan(out_chan)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected event queues
  int    e_kind [$];
  int    e_chan [$];
  string e_req  [$];
  int    e_data [$];
  int    e_err  [$];
  int    cur_kind = -1;
  int    cur_chan = 0;

  function automatic void model(input logic [7:0] q [$], output int k, output int c);
    int  n = q.size();
    bit  dh = 1'b0;
    bit  mh = 1'b0;
    int  mi = 0;
    bit  rid;
    k = 0;
    c = 0;
    if (n > 0) begin
      dh = ((q[0] ^ dflt_addr) & ~dflt_mask) == 8'h00;
      for (int i = 0; i < N_CH; i++) begin
        logic [7:0] ea, em;
        ea = ch_sep[i] ? a_cfg[i] : dflt_addr;
        em = ch_sep[i] ? m_cfg[i] : dflt_mask;
        if (!mh && ch_en[i] && (((q[0] ^ ea) & ~em) == 8'h00)) begin
          mh = 1'b1;
          mi = i;
        end
      end
    end
    rid = rmap_en && n >= 2 && q[1] == 8'h01;
    if (rid && n < 3) k = 0;
    else if (rid && q[2][6]) begin
      if (dh) k = 2;
      else if (mh) begin k = 1; c = mi; end
      else k = 2;
    end else if (n < (promisc ? 1 : 2)) k = 0;
    else if (mh) begin k = 1; c = mi; end
  endfunction

  task automatic put(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_kind  = k;
    rx_data  = d;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
                      input logic [1:0] endk, input string req);
    logic [7:0] q [$];
    logic [7:0] all [5];
    int k, c;
    all[0] = b0; all[1] = b1; all[2] = b2; all[3] = b3; all[4] = b4;
    for (int i = 0; i < n; i++) q.push_back(all[i]);
    model(q, k, c);
    e_kind.push_back(k);
    e_chan.push_back(c);
    e_req.push_back(req);
    if (k != 0) begin
      foreach (q[i]) e_data.push_back(int'(q[i]));
      e_err.push_back(endk == 2'd2 ? 1 : 0);
    end
    foreach (q[i]) put(2'd0, q[i]);
    put(endk, 8'h00);
  endtask

  task automatic drain();
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_valid) begin
        if (e_kind.size() == 0) chk(1'b0, "R9 unexpected decision", int'(dec_kind), -1);
        else begin
          int k, c;
          string r;
          k = e_kind.pop_front();
          c = e_chan.pop_front();
          r = e_req.pop_front();
          chk(int'(dec_kind) == k, r, int'(dec_kind), k);
          if (k == 1) chk(int'(dec_chan) == c, r, int'(dec_chan), c);
          cur_kind = (k == 0) ? -1 : k;
          cur_chan = c;
        end
      end
      if (out_valid) begin
        chk(cur_kind != -1, "R9 data without decision", 1, 0);
        chk(int'(out_kind) == cur_kind, "R11 out_kind", int'(out_kind), cur_kind);
        if (cur_kind == 1) chk(int'(out_chan) == cur_chan, "R11 out_chan", int'(out_chan), cur_chan);
        if (e_data.size() == 0) chk(1'b0, "R8 extra data", int'(out_data), -1);
        else begin
          int d;
          d = e_data.pop_front();
          chk(int'(out_data) == d, "R8 data", int'(out_data), d);
        end
      end
      if (out_end) begin
        if (e_err.size() == 0) chk(1'b0, "R6 unexpected end", 1, 0);
        else begin
          int x;
          x = e_err.pop_front();
          chk(int'(out_end_err) == x, "R8 end flag", int'(out_end_err), x);
        end
        cur_kind = -1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    logic [7:0] pick [8];
    rst = 1'b1;
    rx_valid = 1'b0; rx_kind = 2'd0; rx_data = 8'h00;
    dflt_addr = 8'h20; dflt_mask = 8'h00;
    a_cfg[0] = 8'h40; m_cfg[0] = 8'h0F;
    a_cfg[1] = 8'h44; m_cfg[1] = 8'h00;
    a_cfg[2] = 8'h00; m_cfg[2] = 8'h00;
    a_cfg[3] = 8'h80; m_cfg[3] = 8'h7F;
    ch_sep = 4'b1011; ch_en = 4'b1111;
    promisc = 1'b0; rmap_en = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(rx_ready == 1'b1, "R10 rx_ready", int'(rx_ready), 1);
    chk(!out_valid && !out_end && !dec_valid, "R10 outputs idle",
        int'({out_valid, out_end, dec_valid}), 0);

    send(4, 8'h43, 8'h10, 8'h22, 8'h33, 0, 2'd1, "R1 masked range to ch0");
    send(2, 8'h44, 8'h05, 0, 0, 0, 2'd1, "R2 ch0 beats ch1");
    drain();
    ch_en = 4'b1110;
    send(3, 8'h44, 8'h05, 8'h06, 0, 0, 2'd1, "R2 disabled ch0 skipped");
    send(2, 8'h20, 8'h07, 0, 0, 0, 2'd1, "R3 default pair ch2");
    send(5, 8'h90, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 2'd2, "R8 error end to ch3");
    send(4, 8'h55, 8'h02, 8'h03, 8'h04, 0, 2'd1, "R6 unmatched dropped");
    send(2, 8'h20, 8'h09, 0, 0, 0, 2'd1, "R6 next packet after drop");
    drain();
    ch_en = 4'b1111;
    send(4, 8'h20, 8'h01, 8'h40, 8'h11, 0, 2'd1, "R4 command to target");
    send(3, 8'h45, 8'h01, 8'h4C, 0, 0, 2'd1, "R5 command to channel");
    send(3, 8'h66, 8'h01, 8'h40, 0, 0, 2'd1, "R5 command no match to target");
    send(3, 8'h66, 8'h01, 8'h00, 0, 0, 2'd1, "R4 reply unmatched dropped");
    send(3, 8'h20, 8'h01, 8'h00, 0, 0, 2'd1, "R4 reply to channel");
    send(2, 8'h43, 8'h09, 0, 0, 0, 2'd1, "R7 two chars delivered");
    send(2, 8'h20, 8'h01, 0, 0, 0, 2'd1, "R7 short tagged dropped");
    send(1, 8'h20, 0, 0, 0, 0, 2'd1, "R7 single char dropped");
    send(0, 0, 0, 0, 0, 0, 2'd1, "R7 empty dropped");
    drain();
    rmap_en = 1'b0;
    send(4, 8'h66, 8'h01, 8'h40, 8'h11, 0, 2'd1, "R6 command without target dropped");
    send(3, 8'h20, 8'h01, 8'h40, 0, 0, 2'd1, "R4 command treated plain");
    drain();
    promisc = 1'b1;
    send(1, 8'h20, 0, 0, 0, 0, 2'd2, "R7 promiscuous single char");
    drain();
    promisc = 1'b0;
    dflt_mask = 8'h03;
    send(2, 8'h23, 8'h00, 0, 0, 0, 2'd1, "R3 default mask range");
    drain();
    ch_sep = 4'b1010;
    send(2, 8'h22, 8'h00, 0, 0, 0, 2'd1, "R3 ch0 on default pair");
    drain();

    pick[0] = 8'h20; pick[1] = 8'h43; pick[2] = 8'h44; pick[3] = 8'h90;
    pick[4] = 8'h55; pick[5] = 8'h23; pick[6] = 8'h4F; pick[7] = 8'hFF;
    for (int p = 0; p < 60; p++) begin
      int n;
      logic [7:0] b1, b2;
      lfsr = step(lfsr); n = int'(lfsr[2:0]) % 6;
      lfsr = step(lfsr); b1 = lfsr[0] ? 8'h01 : lfsr[15:8];
      lfsr = step(lfsr); b2 = lfsr[7:0];
      if (p % 10 == 0) begin
        drain();
        rmap_en = lfsr[3];
        promisc = lfsr[4];
        ch_en   = lfsr[11:8] | 4'b0100;
      end
      lfsr = step(lfsr);
      send(n, pick[lfsr[2:0]], b1, b2, lfsr[15:8], 8'h5A,
           lfsr[5] ? 2'd2 : 2'd1, "R8 mixed traffic");
    end
    drain();
    chk(e_kind.size() == 0, "R9 decisions outstanding", e_kind.size(), 0);
    chk(e_data.size() == 0, "R8 data outstanding", e_data.size(), 0);
    chk(e_err.size() == 0, "R8 ends outstanding", e_err.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule